// File: doc/BRIEF.md
# DAC Output Clamp and Deglitch Sequencer

This block sequences the digital side of a DAC output stage. It drives two analog switch enables: one that connects the buffer amplifier to the output pin, and one that shorts the output pin to ground. The ground clamp holds from reset until the supplies are reported good and a data word has been written to the DAC register after that. It comes back whenever the supplies drop or the active-low external reset input is pulled low. Leaving the clamp again always takes a fresh register write while both conditions are healthy.

The block also drives the track/hold control of the output buffer. A falling edge on the active-low load strobe, seen while the output is driven, puts the buffer into hold for a fixed time. That time is set in nanoseconds and turned into clock cycles from the clock frequency, with 5 µs as the default. The hold hides the glitch of the code change. When the load strobe is tied low there is no falling edge, so the buffer never holds. The synchronised supply status is passed out on an active-low output for other parts of the system.

The supply flag and the external reset are asynchronous, so each goes through a synchroniser before the state machine uses it. The write strobe and load strobe are taken as synchronous to the clock.

Top module: `dacguard_top`

## Requirements
- R1: When `rst` is high, the outputs go to `clamp_en_o`=1, `path_en_o`=0, `hold_o`=0 and `supply_rst_n_o`=0. After reset, both the supply and the external reset are taken as bad until they have passed through the synchronisers.
- R2: `supply_rst_n_o` takes the value that `supply_ok_i` had two rising clock edges earlier.
- R3: A pulse on `reg_wr_i` has no effect while a fault is seen. A fault is the synchronised supply flag being low or the synchronised `ext_rst_n_i` being low. The output stays clamped.
- R4: With no fault, `reg_wr_i` high at a rising edge makes `clamp_en_o` fall after that edge. `path_en_o` then rises after the next edge.
- R5: `path_en_o` and `clamp_en_o` are never high together. Every change between them passes through exactly one cycle with both low.
- R6: In the driving state, a low on `supply_ok_i` or on `ext_rst_n_i` before edge k makes `path_en_o` fall after edge k+2. `clamp_en_o` then rises after edge k+3.
- R7: Once a fault has cleared, the output stays clamped until a new `reg_wr_i` arrives.
- R8: While `path_en_o` is high, a falling edge on `load_n_i` sets `hold_o` high for exactly HOLD_CYCLES cycles, starting after the edge where `load_n_i` is first sampled low. HOLD_CYCLES = ceil(CLK_HZ × HOLD_NS / 10^9), which is 1000 with the defaults.
- R9: A new falling edge of `load_n_i` during a hold restarts the count. `hold_o` then stays high for HOLD_CYCLES cycles counted from the latest edge.
- R10: If `load_n_i` stays low the whole time, `hold_o` never goes high.
- R11: `hold_o` is never high while `clamp_en_o` is high. A falling edge of `load_n_i` while the path is off is ignored. A running hold is cleared once the path drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok_i | input | 1 | Supply-valid flag from the analog monitor (asynchronous) |
| ext_rst_n_i | input | 1 | External reset, active low (asynchronous) |
| reg_wr_i | input | 1 | Strobe for a DAC data register write |
| load_n_i | input | 1 | Load strobe, active low; its falling edge starts a hold |
| path_en_o | output | 1 | Connects the amplifier to the output pin |
| clamp_en_o | output | 1 | Shorts the output pin to ground |
| hold_o | output | 1 | Buffer hold (1) or track (0) |
| supply_rst_n_o | output | 1 | Synchronised supply status, low when the supply is bad |

## Verification
A gate state machine stuck in the wrong state shows up at the two enable ports within one cycle. Both enables high at once, or a missing break gap, appears on the same edge as the transition. A stale arm left over from a write during a fault would release the clamp after the fault clears with no new write; the bench watches those cycles in which no write is given. A wrong hold counter shows up as a hold pulse longer or shorter than HOLD_CYCLES, counted cycle by cycle. A wrong edge detector shows up either as a hold when the load strobe is tied low, or as no restart when a second edge falls inside a hold.

// File: rtl/dacguard_pkg.sv
package dacguard_pkg;

    // Gate sequencer states; the two gap states give break-before-make.
    typedef enum logic [1:0] {
        ST_CLAMP = 2'd0,
        ST_MAKE  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_BREAK = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic clamp;
        logic path;
    } gate_ctl_t;

    typedef struct packed {
        logic supply_ok;
        logic ext_ok;
    } monitor_t;

    localparam monitor_t MONITOR_RESET = '{supply_ok: 1'b0, ext_ok: 1'b0};

    function automatic gate_ctl_t decode_gates(gate_state_e s);
        gate_ctl_t g;
        g.clamp = (s == ST_CLAMP);
        g.path  = (s == ST_DRIVE);
        return g;
    endfunction

    // Cycles covering a time in ns, rounded up, never below one.
    function automatic int unsigned cycles_for_ns(longint unsigned clk_hz,
                                                  longint unsigned ns);
        longint unsigned c;
        c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/dacguard_sync.sv
module dacguard_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RESET_VAL;
                    else     stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RESET_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dacguard_gate_fsm.sv
module dacguard_gate_fsm
    import dacguard_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fault_i,
    input  logic      wr_i,
    output gate_ctl_t gates_o
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLAMP: if (!fault_i && wr_i) state_d = ST_MAKE;
            ST_MAKE:  state_d = fault_i ? ST_CLAMP : ST_DRIVE;
            ST_DRIVE: if (fault_i) state_d = ST_BREAK;
            ST_BREAK: state_d = ST_CLAMP;
            default:  state_d = ST_CLAMP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CLAMP;
        else     state_q <= state_d;
    end

    assign gates_o = decode_gates(state_q);
endmodule

// File: rtl/dacguard_hold_timer.sv
module dacguard_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 1000,
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load_n_i,
    input  logic enable_i,
    output logic hold_o
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

    logic             load_n_q;
    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fall;

    assign fall = load_n_q && !load_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_n_q <= 1'b1;
            hold_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            load_n_q <= load_n_i;
            if (!enable_i) begin
                hold_q <= 1'b0;
                cnt_q  <= '0;
            end else if (fall) begin
                hold_q <= 1'b1;
                cnt_q  <= RELOAD;
            end else if (hold_q) begin
                if (cnt_q == '0) hold_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/dacguard_top.sv
module dacguard_top
    import dacguard_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 200_000_000,
    parameter longint unsigned HOLD_NS     = 5000,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic ext_rst_n_i,
    input  logic reg_wr_i,
    input  logic load_n_i,
    output logic path_en_o,
    output logic clamp_en_o,
    output logic hold_o,
    output logic supply_rst_n_o
);
    localparam int unsigned HOLD_CYCLES = cycles_for_ns(CLK_HZ, HOLD_NS);

    monitor_t  mon_raw, mon_s;
    gate_ctl_t gates;
    logic      fault;

    assign mon_raw.supply_ok = supply_ok_i;
    assign mon_raw.ext_ok    = ext_rst_n_i;

    dacguard_sync #(
        .WIDTH    ($bits(monitor_t)),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(MONITOR_RESET)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(mon_raw),
        .q_o(mon_s)
    );

    assign fault = !mon_s.supply_ok || !mon_s.ext_ok;

    dacguard_gate_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .fault_i(fault),
        .wr_i   (reg_wr_i),
        .gates_o(gates)
    );

    dacguard_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load_n_i(load_n_i),
        .enable_i(gates.path),
        .hold_o  (hold_o)
    );

    assign path_en_o      = gates.path;
    assign clamp_en_o     = gates.clamp;
    assign supply_rst_n_o = mon_s.supply_ok;
endmodule

// File: rtl/dacguard_checker.sv
module dacguard_checker (
    input logic clk,
    input logic rst,
    input logic reg_wr_i,
    input logic load_n_i,
    input logic path_en_o,
    input logic clamp_en_o,
    input logic hold_o,
    input logic supply_rst_n_o
);
    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(path_en_o && clamp_en_o)); // R5
    AST_MAKE_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(path_en_o) |-> !$past(clamp_en_o)); // R5
    AST_BREAK_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_en_o) |-> !$past(path_en_o)); // R5
    AST_PATH_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(path_en_o) |-> $past(reg_wr_i, 2)); // R4
    AST_NO_HOLD_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        clamp_en_o |-> !hold_o); // R11
    AST_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_o) |-> (!$past(load_n_i) && $past(load_n_i, 2))); // R8
    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (rst)
        !supply_rst_n_o |=> !path_en_o); // R6
endmodule

bind dacguard_top dacguard_checker u_chk (.*);

// File: tb/dacguard_top_test.sv
`timescale 1ns/1ps
module dacguard_top_test;
    localparam int HOLD = 1000;   // R8: ceil(200e6 * 5000 / 1e9)
    localparam int NVEC = 20;
    localparam int WATCHDOG = 100000;

    typedef struct packed {
        logic        sup;
        logic        ext;
        logic        wr;
        logic        ld;
        logic [3:0]  exp;   // {clamp, path, hold, supply_rst_n}
        logic [23:0] tag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'b1000, "R3 "},
        '{1'b1, 1'b1, 1'b1, 1'b1, 4'b1001, "R3 "},
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'b1001, "R2 "},
        '{1'b1, 1'b1, 1'b1, 1'b1, 4'b0001, "R4 "},
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'b0101, "R4 "},
        '{1'b1, 1'b1, 1'b0, 1'b0, 4'b0111, "R8 "},
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'b0111, "R8 "},
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0111, "R6 "},
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0111, "R6 "},
        '{1'b1, 1'b0, 1'b1, 1'b1, 4'b0011, "R6 "},
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'b1001, "R11"},
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'b1001, "R7 "},
        '{1'b1, 1'b1, 1'b1, 1'b1, 4'b1001, "R3 "},
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'b1001, "R7 "},
        '{1'b1, 1'b1, 1'b1, 1'b1, 4'b0001, "R4 "},
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'b0101, "R5 "},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b0101, "R6 "},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b0100, "R2 "},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, "R6 "},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b1000, "R6 "}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok_i = 1'b0;
    logic ext_rst_n_i = 1'b1;
    logic reg_wr_i = 1'b0;
    logic load_n_i = 1'b1;
    logic path_en_o, clamp_en_o, hold_o, supply_rst_n_o;

    int n_checks = 0;
    int n_fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dacguard_top uut (
        .clk           (clk),
        .rst           (rst),
        .supply_ok_i   (supply_ok_i),
        .ext_rst_n_i   (ext_rst_n_i),
        .reg_wr_i      (reg_wr_i),
        .load_n_i      (load_n_i),
        .path_en_o     (path_en_o),
        .clamp_en_o    (clamp_en_o),
        .hold_o        (hold_o),
        .supply_rst_n_o(supply_rst_n_o)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        supply_ok_i = 1'b0;
        ext_rst_n_i = 1'b1;
        reg_wr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bring_up();
        supply_ok_i = 1'b1;
        ext_rst_n_i = 1'b1;
        reg_wr_i = 1'b0;
        repeat (3) @(negedge clk);
        reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
        @(negedge clk);
        check("R4 bring-up path", int'(path_en_o), 1);
    endtask

    // Drive a falling load edge, then count cycles of hold from the next sample.
    task automatic count_hold(output int n);
        n = 0;
        load_n_i = 1'b0;
        for (int i = 0; i < HOLD + 10; i++) begin
            @(negedge clk);
            if (hold_o) n++;
            else break;
        end
    endtask

    initial begin
        int n;
        int seen;
        string tag;

        // R1: reset state
        load_n_i = 1'b1;
        do_reset();
        check("R1 clamp", int'(clamp_en_o), 1);
        check("R1 path", int'(path_en_o), 0);
        check("R1 hold", int'(hold_o), 0);
        check("R1 supply_rst_n", int'(supply_rst_n_o), 0);

        // Table walk: power-up, deglitch, brown-out, reload, supply loss
        for (int i = 0; i < NVEC; i++) begin
            supply_ok_i = VECS[i].sup;
            ext_rst_n_i = VECS[i].ext;
            reg_wr_i    = VECS[i].wr;
            load_n_i    = VECS[i].ld;
            @(negedge clk);
            tag = string'(VECS[i].tag);
            check($sformatf("%s row %0d", tag, i),
                  int'({clamp_en_o, path_en_o, hold_o, supply_rst_n_o}),
                  int'(VECS[i].exp));
        end
        reg_wr_i = 1'b0;
        load_n_i = 1'b1;

        // R8: exact hold length
        bring_up();
        count_hold(n);
        check("R8 hold length", n, HOLD);
        load_n_i = 1'b1;
        @(negedge clk);

        // R9: retrigger during hold
        load_n_i = 1'b0;
        repeat (300) @(negedge clk);
        load_n_i = 1'b1;
        @(negedge clk);
        check("R9 hold still high", int'(hold_o), 1);
        count_hold(n);
        check("R9 restarted length", n, HOLD);
        load_n_i = 1'b1;
        @(negedge clk);

        // R11: hold cleared on brown-out, never with clamp
        load_n_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 hold started", int'(hold_o), 1);
        ext_rst_n_i = 1'b0;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (hold_o && clamp_en_o) seen++;
        end
        check("R11 hold with clamp", seen, 0);
        check("R11 hold cleared", int'(hold_o), 0);
        check("R6 clamped after ext reset", int'(clamp_en_o), 1);

        // R11: edge while clamped is ignored
        load_n_i = 1'b1;
        @(negedge clk);
        load_n_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11 edge while clamped", int'(hold_o), 0);

        // R7: fault cleared but no write keeps clamp for many cycles
        ext_rst_n_i = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 clamp held", int'(clamp_en_o), 1);
        check("R7 path off", int'(path_en_o), 0);

        // R10: load strobe tied low from reset
        load_n_i = 1'b0;
        do_reset();
        bring_up();
        seen = 0;
        for (int i = 0; i < HOLD + 100; i++) begin
            @(negedge clk);
            if (hold_o) seen++;
        end
        check("R10 no hold when tied low", seen, 0);
        check("R10 path active", int'(path_en_o), 1);

        // R1: reset in the middle of driving
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run clamp", int'(clamp_en_o), 1);
        check("R1 mid-run path", int'(path_en_o), 0);
        check("R1 mid-run supply_rst_n", int'(supply_rst_n_o), 0);
        rst = 1'b0;

        finish_run();
    end
endmodule